// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Almost Flags

This block is a first-in first-out buffer of 36-bit words with a write port and a read port. Each port has its own clock, and the two clocks may be unrelated. The depth is a parameter of 256, 512 or 1024 words. Each port accepts a transfer only when its enable is high, its active-low chip select is low, its direction bit points the right way and its mailbox select is low. The read port moves the oldest word into an output register. A word in that register is no longer counted as stored.

Each side has an active-low almost flag, computed from the local pointer and a copy of the remote pointer. The remote pointer crosses as Gray code through a two-flop synchronizer. The almost-empty flag lives in the read clock domain and compares the stored count against a static offset X. The almost-full flag lives in the write clock domain and compares the free space against a static offset Y. A local transfer shows in the local flag at once. A transfer on the far side shows after exactly two local clock edges.

Top module: `dcfifo_almost_flags`

## Requirements
- R1: While rst_ni is low, almost_empty_no is 0, almost_full_no is 1 and rd_data_o is 0.
- R2: A write is accepted on a rising wclk_i edge only when wr_en_i=1, wr_cs_ni=0, wr_dir_i=1 and wr_mbx_i=0. Any other combination leaves the FIFO unchanged.
- R3: A read is accepted on a rising rclk_i edge only when rd_en_i=1, rd_cs_ni=0, rd_dir_i=1 and rd_mbx_i=0. Any other combination leaves the FIFO unchanged.
- R4: Words leave in the order they were written. An accepted read loads the oldest word into rd_data_o at that same rclk_i edge, and the word no longer counts as stored.
- R5: Take the stored count as the read side sees it. almost_empty_no is 0 while that count is at most ae_x_i, and 1 once it is ae_x_i+1 or more. An accepted read updates the flag at the read edge itself.
- R6: A write edge changes the count seen by the read side on the second rising rclk_i edge after the write edge.
- R7: Take the stored count as the write side sees it. almost_full_no is 0 while that count is at least DEPTH-af_y_i, and 1 otherwise. A local write updates the flag at once. A read changes the flag on the second rising wclk_i edge after the read edge.
- R8: A write while the write side sees DEPTH words is dropped. A read while the read side sees zero words is dropped, and rd_data_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | Write enable |
| wr_cs_ni | input | 1 | Write port chip select, active low |
| wr_dir_i | input | 1 | Write port direction, 1 = write |
| wr_mbx_i | input | 1 | Write port mailbox select, must be 0 |
| wr_data_i | input | WIDTH | Word to store |
| rd_en_i | input | 1 | Read enable |
| rd_cs_ni | input | 1 | Read port chip select, active low |
| rd_dir_i | input | 1 | Read port direction, 1 = read |
| rd_mbx_i | input | 1 | Read port mailbox select, must be 0 |
| rd_data_o | output | WIDTH | Output register with the last word read |
| ae_x_i | input | AW | Almost-empty offset X, static, below DEPTH/2 |
| af_y_i | input | AW | Almost-full offset Y, static, below DEPTH/2 |
| almost_empty_no | output | 1 | Almost-empty flag, read domain, active low |
| almost_full_no | output | 1 | Almost-full flag, write domain, active low |

## Verification
The read data and the local half of each flag are due just after the accepting edge of the same clock. A transfer on the far side is due in the flag on the second local edge after it. The bench phases the two clocks so that their rising edges never coincide, which means the skew window that adds a cycle never opens. The reference model keeps two-deep delay lines, each stepped on the observing clock's edges. The bench compares the model with the outputs on the falling edge of that same clock, once every cycle, so a flag that is one cycle early or late is seen.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int unsigned WORD_W = 36;
  localparam int unsigned GW     = 16;

  function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int WIDTH = 36,
  parameter int AW    = 8
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;
  logic [WIDTH-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cs_ni,
  input  logic          dir_i,
  input  logic          mbx_i,
  input  logic [AW-1:0] y_i,
  input  logic [PW-1:0] rgray_i,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          fire_o,
  output logic          full_o,
  output logic          af_no
);
  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s, used;

  assign rbin_s   = PW'(gray2bin(GW'(rgray_i)));
  assign used     = wbin_q - rbin_s;
  assign full_o   = (used == PW'(DEPTH));
  assign fire_o   = en_i & ~cs_ni & dir_i & ~mbx_i & ~full_o;
  assign wbin_nxt = wbin_q + PW'(1);
  // low while free space is Y words or less
  assign af_no    = !(used >= (PW'(DEPTH) - PW'(y_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (fire_o) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= PW'(bin2gray(GW'(wbin_nxt)));
    end
  end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
  import dcfifo_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cs_ni,
  input  logic             dir_i,
  input  logic             mbx_i,
  input  logic [AW-1:0]    x_i,
  input  logic [PW-1:0]    wgray_i,
  input  logic [WIDTH-1:0] mem_rdata_i,
  output logic [PW-1:0]    rbin_o,
  output logic [PW-1:0]    rgray_o,
  output logic             fire_o,
  output logic             empty_o,
  output logic             ae_no,
  output logic [WIDTH-1:0] data_o
);
  logic [PW-1:0]    rbin_q, rgray_q, rbin_nxt, wbin_s, used;
  logic [WIDTH-1:0] data_q;

  assign wbin_s   = PW'(gray2bin(GW'(wgray_i)));
  assign used     = wbin_s - rbin_q;
  assign empty_o  = (used == '0);
  assign fire_o   = en_i & ~cs_ni & dir_i & ~mbx_i & ~empty_o;
  assign rbin_nxt = rbin_q + PW'(1);
  assign ae_no    = (used > PW'(x_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
    end else if (fire_o) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= PW'(bin2gray(GW'(rbin_nxt)));
      data_q  <= mem_rdata_i;
    end
  end

  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
  assign data_o  = data_q;
endmodule

// File: rtl/dcfifo_almost_flags.sv
module dcfifo_almost_flags #(
  parameter int DEPTH = 256,
  parameter int WIDTH = dcfifo_pkg::WORD_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_cs_ni,
  input  logic             wr_dir_i,
  input  logic             wr_mbx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             rd_cs_ni,
  input  logic             rd_dir_i,
  input  logic             rd_mbx_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic [AW-1:0]    ae_x_i,
  input  logic [AW-1:0]    af_y_i,
  output logic             almost_empty_no,
  output logic             almost_full_no
);
  localparam int PW = AW + 1;

  logic [PW-1:0]    wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic             wr_fire, rd_fire, wr_full, rd_empty;
  logic [WIDTH-1:0] mem_rdata;

  fifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni),
    .en_i(wr_en_i), .cs_ni(wr_cs_ni), .dir_i(wr_dir_i), .mbx_i(wr_mbx_i),
    .y_i(af_y_i), .rgray_i(rgray_s),
    .wbin_o(wbin), .wgray_o(wgray), .fire_o(wr_fire), .full_o(wr_full),
    .af_no(almost_full_no)
  );

  fifo_rd_ctrl #(.WIDTH(WIDTH), .AW(AW), .PW(PW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni),
    .en_i(rd_en_i), .cs_ni(rd_cs_ni), .dir_i(rd_dir_i), .mbx_i(rd_mbx_i),
    .x_i(ae_x_i), .wgray_i(wgray_s), .mem_rdata_i(mem_rdata),
    .rbin_o(rbin), .rgray_o(rgray), .fire_o(rd_fire), .empty_o(rd_empty),
    .ae_no(almost_empty_no), .data_o(rd_data_o)
  );

  gray_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s));
  gray_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s));

  fifo_ram #(.WIDTH(WIDTH), .AW(AW)) u_ram (
    .clk_i(wclk_i), .we_i(wr_fire), .waddr_i(wbin[AW-1:0]), .wdata_i(wr_data_i),
    .raddr_i(rbin[AW-1:0]), .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/dcfifo_flag_chk.sv
module dcfifo_flag_chk #(
  parameter int PW    = 9,
  parameter int WIDTH = 36
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic [PW-1:0]    wbin_i,
  input logic [PW-1:0]    rbin_i,
  input logic [PW-1:0]    wgray_i,
  input logic [PW-1:0]    rgray_i,
  input logic             wr_full_i,
  input logic             rd_empty_i,
  input logic             rd_fire_i,
  input logic [WIDTH-1:0] rd_data_i,
  input logic             ae_ni,
  input logic             af_ni
);
  AST_RESET_AE_LOW: assert property (@(posedge rclk_i) !rst_ni |-> !ae_ni); // R1
  AST_RESET_AF_HIGH: assert property (@(posedge wclk_i) !rst_ni |-> af_ni); // R1
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_full_i |=> $stable(wbin_i)); // R8
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_empty_i |=> $stable(rbin_i)); // R8
  AST_DATA_HELD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_fire_i |=> $stable(rd_data_i)); // R4
  AST_WGRAY_ONE_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1); // R6
  AST_RGRAY_ONE_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_i ^ $past(rgray_i)) <= 1); // R7
  AST_FULL_FLAGGED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_full_i |-> !af_ni); // R7
  AST_EMPTY_FLAGGED: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_empty_i |-> !ae_ni); // R5
endmodule

bind dcfifo_almost_flags dcfifo_flag_chk #(.PW(PW), .WIDTH(WIDTH)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wbin_i(wbin), .rbin_i(rbin), .wgray_i(wgray), .rgray_i(rgray),
  .wr_full_i(wr_full), .rd_empty_i(rd_empty), .rd_fire_i(rd_fire),
  .rd_data_i(rd_data_o), .ae_ni(almost_empty_no), .af_ni(almost_full_no)
);

// File: tb/sim_dcfifo_almost_flags.sv
`timescale 1ns/1ps
module sim_dcfifo_almost_flags;
  localparam int DEPTH = 256;
  localparam int WIDTH = 36;
  localparam int AW    = $clog2(DEPTH);
  localparam int XOFF  = 4;
  localparam int YOFF  = 4;

  logic wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b1;
  logic wr_en = 0, wr_cs_n = 1, wr_dir = 0, wr_mbx = 0;
  logic rd_en = 0, rd_cs_n = 1, rd_dir = 0, rd_mbx = 0;
  logic [WIDTH-1:0] wr_data = '0, rd_data;
  logic ae_n, af_n;

  int total = 0, bad = 0;
  int wcnt = 0, rcnt = 0, ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
  bit rd_hit = 0, done = 0;
  logic [WIDTH-1:0] exp_data = '0, dval = 36'h1_0000_0000;
  logic [WIDTH-1:0] sb_q[$];

  dcfifo_almost_flags #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_cs_ni(wr_cs_n), .wr_dir_i(wr_dir), .wr_mbx_i(wr_mbx),
    .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_cs_ni(rd_cs_n), .rd_dir_i(rd_dir), .rd_mbx_i(rd_mbx),
    .rd_data_o(rd_data), .ae_x_i(AW'(XOFF)), .af_y_i(AW'(YOFF)),
    .almost_empty_no(ae_n), .almost_full_no(af_n)
  );

  // 100 MHz write clock; read clock 14 ns, phased so rising edges never coincide
  always #5 wclk = ~wclk;
  initial begin #3; forever #7 rclk = ~rclk; end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: accept rules and two-edge visibility of remote counts
  always @(posedge wclk) if (rst_ni) begin
    if (wr_en && !wr_cs_n && wr_dir && !wr_mbx && (wcnt - ws2) != DEPTH) begin
      sb_q.push_back(wr_data);
      wcnt++;
    end
    ws2 = ws1;
    ws1 = rcnt;
  end

  always @(posedge rclk) if (rst_ni) begin
    rd_hit = 0;
    if (rd_en && !rd_cs_n && rd_dir && !rd_mbx && (rs2 - rcnt) != 0) begin
      exp_data = sb_q.pop_front();
      rcnt++;
      rd_hit = 1;
    end
    rs2 = rs1;
    rs1 = wcnt;
  end

  // monitors
  always @(negedge rclk) if (rst_ni && !done) begin
    chk("R6 almost-empty timing", 64'(ae_n), 64'((rs2 - rcnt) > XOFF));
    if (rd_hit) chk("R4 read data order", 64'(rd_data), 64'(exp_data));
    else        chk("R8 output held", 64'(rd_data), 64'(exp_data));
  end

  always @(negedge wclk) if (rst_ni && !done)
    chk("R7 almost-full timing", 64'(af_n), 64'(!((wcnt - ws2) >= DEPTH - YOFF)));

  task automatic wr_cyc(input logic en, input logic cs_n, input logic dir, input logic mbx);
    @(negedge wclk);
    wr_en = en; wr_cs_n = cs_n; wr_dir = dir; wr_mbx = mbx;
    wr_data = dval; dval = dval + 36'd1;
  endtask

  task automatic wr_idle(input int n);
    @(negedge wclk); wr_en = 0; wr_cs_n = 1;
    repeat (n) @(negedge wclk);
  endtask

  task automatic rd_cyc(input logic en, input logic cs_n, input logic dir, input logic mbx);
    @(negedge rclk);
    rd_en = en; rd_cs_n = cs_n; rd_dir = dir; rd_mbx = mbx;
  endtask

  task automatic rd_idle(input int n);
    @(negedge rclk); rd_en = 0; rd_cs_n = 1;
    repeat (n) @(negedge rclk);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    #20;
    chk("R1 reset almost-empty", 64'(ae_n), 64'(0));
    chk("R1 reset almost-full", 64'(af_n), 64'(1));
    chk("R1 reset data", 64'(rd_data), 64'(0));
    #19 rst_ni = 1'b1;

    // R2: three good writes among disqualified attempts
    wr_cyc(1, 0, 1, 0); wr_cyc(0, 0, 1, 0); wr_cyc(1, 1, 1, 0);
    wr_cyc(1, 0, 1, 0); wr_cyc(1, 0, 0, 0); wr_cyc(1, 0, 1, 1);
    wr_cyc(1, 0, 1, 0);
    wr_idle(8);
    chk("R2 qualifiers block writes, count 3", 64'(ae_n), 64'(0));

    // R5: count to X+1, then one read drops it back at the read edge
    wr_cyc(1, 0, 1, 0); wr_cyc(1, 0, 1, 0);
    wr_idle(8);
    chk("R5 count above X", 64'(ae_n), 64'(1));
    rd_cyc(1, 0, 1, 0);
    rd_idle(0);
    chk("R5 read lowers flag at once", 64'(ae_n), 64'(0));

    // R3: disqualified reads at count X, then one write must raise flag
    rd_cyc(0, 0, 1, 0); rd_cyc(1, 1, 1, 0); rd_cyc(1, 0, 0, 0); rd_cyc(1, 0, 1, 1);
    rd_idle(2);
    wr_cyc(1, 0, 1, 0);
    wr_idle(8);
    chk("R3 qualifiers block reads, count X+1", 64'(ae_n), 64'(1));

    // R8: drain and try reads on empty
    repeat (5) rd_cyc(1, 0, 1, 0);
    repeat (4) rd_cyc(1, 0, 1, 0);
    rd_idle(4);
    chk("R8 empty flag low", 64'(ae_n), 64'(0));

    // R7 / R8: overfill
    repeat (DEPTH + 4) wr_cyc(1, 0, 1, 0);
    wr_idle(6);
    chk("R7 full flags almost-full", 64'(af_n), 64'(0));
    repeat (3) rd_cyc(1, 0, 1, 0);
    rd_idle(2);
    wr_idle(6);
    chk("R7 count D-Y+1 still low", 64'(af_n), 64'(0));
    repeat (2) rd_cyc(1, 0, 1, 0);
    rd_idle(2);
    wr_idle(6);
    chk("R7 count D-Y-1 raises flag", 64'(af_n), 64'(1));

    // concurrent traffic with mixed qualifiers
    fork
      for (int i = 0; i < 120; i++) wr_cyc(1, (i % 5) == 3, 1, (i % 7) == 6);
      for (int i = 0; i < 200; i++) rd_cyc(1, (i % 6) == 2, (i % 9) != 4, 0);
    join
    wr_idle(4);
    rd_idle(4);
    while (rcnt != wcnt) rd_cyc(1, 0, 1, 0);
    rd_idle(4);
    chk("R4 drained, almost-empty low", 64'(ae_n), 64'(0));
    wr_idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule